// File: doc/BRIEF.md
# Multi-Thread Gate Control Scheduler

This block drives the transmission gates of a switch's egress ports from a time-based schedule. A single linear table of timeslot entries is shared by several cyclic execution threads. Each entry gives a hold time in scheduler delta units, a mask of traffic-class gates to close, an enable for that mask, and the set of egress ports the entry applies to. Each thread owns a contiguous slice of the table: its entry-point record gives the first address of the slice and a start offset, and a separate end index closes the slice.

Software writes a common base time, the number of active threads minus one, the per-thread entry-point records and the table entries through simple write strobes, then issues a start command. Each enabled thread waits until the free-running time input, counted in scheduler clock ticks, reaches the base time plus its own offset. It then walks its slice and returns to the first address after the last entry. A stop command returns every thread to idle. For every egress port the block reports whether a running thread claims it and which gates are closed, with the lowest-numbered thread winning when several claim one port.

Top module: `gate_sched`

## Requirements
- R1: After reset all threads are idle; `thr_active`, `port_owned`, `port_closed`, `sched_start` and `cfg_err` are all zero. Table entries reset to a hold of 1 delta with empty masks, start offsets reset to 1 and end indices reset to DEPTH-1.
- R2: After a start command, thread t with t less than or equal to the programmed count-minus-one becomes active on the first clock edge at which `time_now` is at least the base time plus its start offset times TPD ticks; threads with t above that count stay idle.
- R3: A running thread begins at its entry-point address, steps by one address per expired entry, and after the entry at its end index returns to its entry-point address.
- R4: Each table entry stays in effect for exactly its hold value times TPD clock cycles.
- R5: A table write whose hold value is zero is discarded, leaving the stored entry unchanged, and `cfg_err` is high for exactly the one cycle after that write.
- R6: An entry-point write is discarded with the same one-cycle `cfg_err` pulse when its start offset is zero, or when its end index is below the end index of the next lower thread or above that of the next higher thread.
- R7: For egress port p (bits p*8 to p*8+7 of `port_closed`), `port_owned[p]` is high when a running thread's current entry has bit p set in its port mask; the closed mask shown is that entry's gate mask when its enable bit is set, and zero otherwise. An unowned port shows zero.
- R8: When several running threads claim the same port, the port follows the lowest-numbered of them.
- R9: `sched_start` is a one-cycle pulse on the first cycle in which some thread is active after all threads were idle.
- R10: A stop command makes every thread idle on the next clock, clearing all port outputs; a stop given together with a start wins, and a start arriving while threads are not idle does not restart them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| time_now | input | TIME_W | Free-running time in scheduler ticks |
| base_we | input | 1 | Base time write strobe |
| base_wdata | input | TIME_W | Base time value |
| cnt_we | input | 1 | Active thread count write strobe |
| cnt_wdata | input | $clog2(NT) | Number of active threads minus one |
| ep_we | input | 1 | Entry-point record write strobe |
| ep_thr | input | $clog2(NT) | Thread being written |
| ep_addr_w | input | $clog2(DEPTH) | First table address of the thread |
| ep_off_w | input | 8 | Start offset in delta units |
| ep_end_w | input | $clog2(DEPTH) | Last table address of the thread |
| tbl_we | input | 1 | Table entry write strobe |
| tbl_waddr | input | $clog2(DEPTH) | Table address written |
| tbl_delta | input | 8 | Hold time in delta units |
| tbl_gate_en | input | 1 | Enable for the closed-gate mask |
| tbl_closed | input | 8 | Traffic-class gates to close |
| tbl_dest | input | 5 | Egress ports the entry applies to |
| sched_go | input | 1 | Start command |
| sched_stop | input | 1 | Stop command |
| cfg_err | output | 1 | Rejected write, one cycle after it |
| thr_active | output | NT | Per-thread running flag |
| sched_start | output | 1 | Schedule start pulse |
| port_owned | output | 5 | Port is claimed by a running thread |
| port_closed | output | 40 | Closed gates, 8 bits per port |

## Verification
The bench sweeps slice lengths of one to four entries at two table offsets with unequal hold times, so a thread that wraps one entry early or late, restarts at address zero instead of its entry point, or holds an entry one tick too long shows a wrong gate mask within a single schedule period. Activation is checked on the exact tick against the offset, which catches an off-by-one comparison or an offset not scaled by TPD, and a disabled mask must read zero while the port still reads as owned. Two threads with overlapping port masks and staggered offsets expose a reversed priority, and threads beyond the programmed count must stay idle. Rejected writes of a zero hold, a zero offset and an out-of-order end index are followed by a run that would reveal any of them having been stored.

// File: rtl/gcs_pkg.sv
`timescale 1ns/1ps
// Shared widths and types of the gate control scheduler.
// Assumes a fixed eight-class gate set and five egress ports per chip.
package gcs_pkg;
    localparam int GCS_TC    = 8;
    localparam int GCS_PORTS = 5;
    localparam int GCS_DW    = 8;

    typedef struct packed {
        logic [GCS_DW-1:0]    delta;
        logic                 gate_en;
        logic [GCS_TC-1:0]    closed;
        logic [GCS_PORTS-1:0] dest;
    } gcs_entry_t;

    typedef enum logic [1:0] {
        TH_IDLE = 2'd0,
        TH_WAIT = 2'd1,
        TH_RUN  = 2'd2
    } th_state_e;
endpackage

// File: rtl/gcs_cfg.sv
`timescale 1ns/1ps
// Configuration store: base time, thread count, entry-point records and
// the shared timeslot table. Rejects illegal writes and pulses cfg_err.
// Assumes at most one write strobe of each kind per cycle.
module gcs_cfg
    import gcs_pkg::*;
#(
    parameter int NT     = 8,
    parameter int DEPTH  = 16,
    parameter int TIME_W = 32,
    localparam int TW    = $clog2(NT),
    localparam int IW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_we,
    input  logic [TIME_W-1:0] base_wdata,
    input  logic              cnt_we,
    input  logic [TW-1:0]     cnt_wdata,
    input  logic              ep_we,
    input  logic [TW-1:0]     ep_thr,
    input  logic [IW-1:0]     ep_addr_w,
    input  logic [GCS_DW-1:0] ep_off_w,
    input  logic [IW-1:0]     ep_end_w,
    input  logic              tbl_we,
    input  logic [IW-1:0]     tbl_waddr,
    input  gcs_entry_t        tbl_wdata,
    output logic [TIME_W-1:0] base_time,
    output logic [TW-1:0]     cnt_m1,
    output logic [IW-1:0]     ep_addr [NT],
    output logic [GCS_DW-1:0] ep_off [NT],
    output logic [IW-1:0]     ep_end [NT],
    output gcs_entry_t        tbl [DEPTH],
    output logic              cfg_err
);
    logic thr_ok, lo_ok, hi_ok, ep_ok;
    int   tsel;

    // Legality of an entry-point write: nonzero offset, ordered end index.
    always_comb begin
        tsel   = int'(ep_thr);
        thr_ok = (tsel < NT);
        lo_ok  = 1'b1;
        hi_ok  = 1'b1;
        if (thr_ok && tsel > 0)
            lo_ok = (ep_end_w >= ep_end[TW'(tsel - 1)]);
        if (thr_ok && tsel < NT - 1)
            hi_ok = (ep_end_w <= ep_end[TW'(tsel + 1)]);
        ep_ok = thr_ok && lo_ok && hi_ok && (ep_off_w != '0);
    end

    // Register and table storage with reset defaults.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_time <= '0;
            cnt_m1    <= '0;
            cfg_err   <= 1'b0;
            for (int t = 0; t < NT; t++) begin
                ep_addr[t] <= '0;
                ep_off[t]  <= GCS_DW'(1);
                ep_end[t]  <= IW'(DEPTH - 1);
            end
            for (int k = 0; k < DEPTH; k++)
                tbl[k] <= '{delta: GCS_DW'(1), gate_en: 1'b0, closed: '0, dest: '0};
        end else begin
            cfg_err <= (tbl_we && tbl_wdata.delta == '0) || (ep_we && !ep_ok);
            if (base_we)
                base_time <= base_wdata;
            if (cnt_we)
                cnt_m1 <= cnt_wdata;
            if (ep_we && ep_ok) begin
                ep_addr[ep_thr] <= ep_addr_w;
                ep_off[ep_thr]  <= ep_off_w;
                ep_end[ep_thr]  <= ep_end_w;
            end
            if (tbl_we && tbl_wdata.delta != '0)
                tbl[tbl_waddr] <= tbl_wdata;
        end
    end
endmodule

// File: rtl/gcs_thread.sv
`timescale 1ns/1ps
// One execution thread: waits for base time plus its offset, then walks
// its table slice, holding each entry for delta*TPD cycles, and wraps.
// Assumes the caller feeds back the hold value of the entry at idx.
module gcs_thread
    import gcs_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int TIME_W = 32,
    parameter int TPD    = 25,
    localparam int IW    = $clog2(DEPTH),
    localparam int KW    = (TPD > 1) ? $clog2(TPD) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stop,
    input  logic              arm,
    input  logic [TIME_W-1:0] time_now,
    input  logic [TIME_W-1:0] base_time,
    input  logic [IW-1:0]     ep_addr,
    input  logic [GCS_DW-1:0] ep_off,
    input  logic [IW-1:0]     ep_end,
    input  logic [GCS_DW-1:0] cur_delta,
    output logic              active,
    output logic [IW-1:0]     idx
);
    th_state_e         state;
    logic [KW-1:0]     tick;
    logic [GCS_DW-1:0] dcnt;
    logic [TIME_W-1:0] t_start;
    logic              last_tick, last_delta;
    logic [IW-1:0]     next_idx;

    // Start time, end-of-entry detection and the next slice address.
    always_comb begin
        t_start    = base_time + TIME_W'(ep_off) * TIME_W'(TPD);
        last_tick  = (tick == KW'(TPD - 1));
        last_delta = ((GCS_DW+1)'(dcnt) + 1'b1) >= (GCS_DW+1)'(cur_delta);
        if (idx == ep_end || idx == IW'(DEPTH - 1))
            next_idx = ep_addr;
        else
            next_idx = idx + 1'b1;
    end

    // Thread state, tick prescaler, delta counter and slice pointer.
    always_ff @(posedge clk) begin
        if (!rst_n || stop) begin
            state <= TH_IDLE;
            idx   <= '0;
            tick  <= '0;
            dcnt  <= '0;
        end else begin
            unique case (state)
                TH_IDLE: if (arm) state <= TH_WAIT;
                TH_WAIT: if (time_now >= t_start) begin
                    state <= TH_RUN;
                    idx   <= ep_addr;
                    tick  <= '0;
                    dcnt  <= '0;
                end
                TH_RUN: if (last_tick) begin
                    tick <= '0;
                    if (last_delta) begin
                        dcnt <= '0;
                        idx  <= next_idx;
                    end else begin
                        dcnt <= dcnt + 1'b1;
                    end
                end else begin
                    tick <= tick + 1'b1;
                end
                default: state <= TH_IDLE;
            endcase
        end
    end

    assign active = (state == TH_RUN);
endmodule

// File: rtl/gcs_port_mux.sv
`timescale 1ns/1ps
// Per-port selection of the gate mask among running threads; the
// lowest-numbered claiming thread wins. Purely combinational.
module gcs_port_mux
    import gcs_pkg::*;
#(
    parameter int NT = 8
) (
    input  logic [NT-1:0]               active,
    input  logic [NT-1:0]               gate_en,
    input  logic [GCS_TC-1:0]           closed [NT],
    input  logic [GCS_PORTS-1:0]        dest [NT],
    output logic [GCS_PORTS-1:0]        port_owned,
    output logic [GCS_PORTS*GCS_TC-1:0] port_closed
);
    // Scan threads from highest to lowest so the lowest claim lands last.
    always_comb begin
        port_owned  = '0;
        port_closed = '0;
        for (int p = 0; p < GCS_PORTS; p++) begin
            for (int t = NT - 1; t >= 0; t--) begin
                if (active[t] && dest[t][p]) begin
                    port_owned[p] = 1'b1;
                    port_closed[p*GCS_TC +: GCS_TC] = gate_en[t] ? closed[t] : '0;
                end
            end
        end
    end
endmodule

// File: rtl/gate_sched.sv
`timescale 1ns/1ps
// Top of the multi-thread gate control scheduler: configuration store,
// NT execution threads over one shared table, and the per-port selector.
// Assumes time_now advances by one scheduler tick per clock or slower.
module gate_sched
    import gcs_pkg::*;
#(
    parameter int NT     = 8,
    parameter int DEPTH  = 16,
    parameter int TIME_W = 32,
    parameter int TPD    = 25,
    localparam int TW    = $clog2(NT),
    localparam int IW    = $clog2(DEPTH)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [TIME_W-1:0]           time_now,
    input  logic                        base_we,
    input  logic [TIME_W-1:0]           base_wdata,
    input  logic                        cnt_we,
    input  logic [TW-1:0]               cnt_wdata,
    input  logic                        ep_we,
    input  logic [TW-1:0]               ep_thr,
    input  logic [IW-1:0]               ep_addr_w,
    input  logic [GCS_DW-1:0]           ep_off_w,
    input  logic [IW-1:0]               ep_end_w,
    input  logic                        tbl_we,
    input  logic [IW-1:0]               tbl_waddr,
    input  logic [GCS_DW-1:0]           tbl_delta,
    input  logic                        tbl_gate_en,
    input  logic [GCS_TC-1:0]           tbl_closed,
    input  logic [GCS_PORTS-1:0]        tbl_dest,
    input  logic                        sched_go,
    input  logic                        sched_stop,
    output logic                        cfg_err,
    output logic [NT-1:0]               thr_active,
    output logic                        sched_start,
    output logic [GCS_PORTS-1:0]        port_owned,
    output logic [GCS_PORTS*GCS_TC-1:0] port_closed
);
    gcs_entry_t            wdata;
    logic [TIME_W-1:0]     base_time;
    logic [TW-1:0]         cnt_m1;
    logic [IW-1:0]         ep_addr [NT];
    logic [GCS_DW-1:0]     ep_off [NT];
    logic [IW-1:0]         ep_end [NT];
    gcs_entry_t            tbl [DEPTH];
    logic [IW-1:0]         idx [NT];
    gcs_entry_t            cur [NT];
    logic [NT-1:0]         cur_en;
    logic [GCS_TC-1:0]     cur_closed [NT];
    logic [GCS_PORTS-1:0]  cur_dest [NT];
    logic                  any_q;

    assign wdata = '{delta: tbl_delta, gate_en: tbl_gate_en,
                     closed: tbl_closed, dest: tbl_dest};

    gcs_cfg #(.NT(NT), .DEPTH(DEPTH), .TIME_W(TIME_W)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .base_we(base_we), .base_wdata(base_wdata),
        .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
        .ep_we(ep_we), .ep_thr(ep_thr), .ep_addr_w(ep_addr_w),
        .ep_off_w(ep_off_w), .ep_end_w(ep_end_w),
        .tbl_we(tbl_we), .tbl_waddr(tbl_waddr), .tbl_wdata(wdata),
        .base_time(base_time), .cnt_m1(cnt_m1),
        .ep_addr(ep_addr), .ep_off(ep_off), .ep_end(ep_end),
        .tbl(tbl), .cfg_err(cfg_err)
    );

    for (genvar t = 0; t < NT; t++) begin : g_thr
        logic arm;
        // A thread is armed only if it lies within the programmed count.
        assign arm = sched_go && !sched_stop && (TW'(t) <= cnt_m1);
        assign cur[t]        = tbl[idx[t]];
        assign cur_en[t]     = cur[t].gate_en;
        assign cur_closed[t] = cur[t].closed;
        assign cur_dest[t]   = cur[t].dest;

        gcs_thread #(.DEPTH(DEPTH), .TIME_W(TIME_W), .TPD(TPD)) u_thr (
            .clk(clk), .rst_n(rst_n), .stop(sched_stop), .arm(arm),
            .time_now(time_now), .base_time(base_time),
            .ep_addr(ep_addr[t]), .ep_off(ep_off[t]), .ep_end(ep_end[t]),
            .cur_delta(cur[t].delta),
            .active(thr_active[t]), .idx(idx[t])
        );
    end

    gcs_port_mux #(.NT(NT)) u_mux (
        .active(thr_active), .gate_en(cur_en), .closed(cur_closed),
        .dest(cur_dest), .port_owned(port_owned), .port_closed(port_closed)
    );

    // Remember whether any thread ran last cycle, for the start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) any_q <= 1'b0;
        else        any_q <= |thr_active;
    end

    assign sched_start = (|thr_active) && !any_q;
endmodule

// File: rtl/gate_sched_chk.sv
`timescale 1ns/1ps
// Property checker for gate_sched, attached through bind.
module gate_sched_chk
    import gcs_pkg::*;
#(
    parameter int NT     = 8,
    parameter int TIME_W = 32
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [TIME_W-1:0]           time_now,
    input logic [TIME_W-1:0]           base_time,
    input logic                        tbl_we,
    input logic [GCS_DW-1:0]           tbl_delta,
    input logic                        sched_stop,
    input logic                        cfg_err,
    input logic [NT-1:0]               thr_active,
    input logic                        sched_start,
    input logic [GCS_PORTS-1:0]        port_owned,
    input logic [GCS_PORTS*GCS_TC-1:0] port_closed
);
    a_r10_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
        sched_stop |=> thr_active == '0);

    a_r5_zero_hold_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_we && tbl_delta == '0) |=> cfg_err);

    a_r9_pulse_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
        sched_start |-> $past(thr_active) == '0);

    a_r2_not_before_base: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_active & ~$past(thr_active)) != '0 |-> $past(time_now) > $past(base_time));

    a_r7_owner_runs: assert property (@(posedge clk) disable iff (!rst_n)
        port_owned != '0 |-> thr_active != '0);

    for (genvar p = 0; p < GCS_PORTS; p++) begin : g_port
        a_r7_mask_needs_owner: assert property (@(posedge clk) disable iff (!rst_n)
            port_closed[p*GCS_TC +: GCS_TC] != '0 |-> port_owned[p]);
    end
endmodule

bind gate_sched gate_sched_chk #(.NT(NT), .TIME_W(TIME_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .time_now(time_now), .base_time(base_time),
    .tbl_we(tbl_we), .tbl_delta(tbl_delta), .sched_stop(sched_stop),
    .cfg_err(cfg_err), .thr_active(thr_active), .sched_start(sched_start),
    .port_owned(port_owned), .port_closed(port_closed)
);

// File: tb/test_gate_sched.sv
`timescale 1ns/1ps
module test_gate_sched;
    localparam int NT = 4, DEPTH = 8, TW_T = 16, TPD = 2;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic [15:0] tnow = '0;
    logic        base_we = 0, cnt_we = 0, ep_we = 0, tbl_we = 0;
    logic [15:0] base_wdata = '0;
    logic [1:0]  cnt_wdata = '0, ep_thr = '0;
    logic [2:0]  ep_addr_w = '0, ep_end_w = '0, tbl_waddr = '0;
    logic [7:0]  ep_off_w = '0, tbl_delta = '0, tbl_closed = '0;
    logic        tbl_gate_en = 0, sched_go = 0, sched_stop = 0;
    logic [4:0]  tbl_dest = '0;
    logic        cfg_err, sched_start;
    logic [3:0]  thr_active;
    logic [4:0]  port_owned;
    logic [39:0] port_closed;
    int checks = 0, errors = 0;

    always #2 clk = ~clk;

    gate_sched #(.NT(NT), .DEPTH(DEPTH), .TIME_W(TW_T), .TPD(TPD)) i_gate_sched (
        .clk(clk), .rst_n(rst_n), .time_now(tnow),
        .base_we(base_we), .base_wdata(base_wdata),
        .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
        .ep_we(ep_we), .ep_thr(ep_thr), .ep_addr_w(ep_addr_w),
        .ep_off_w(ep_off_w), .ep_end_w(ep_end_w),
        .tbl_we(tbl_we), .tbl_waddr(tbl_waddr), .tbl_delta(tbl_delta),
        .tbl_gate_en(tbl_gate_en), .tbl_closed(tbl_closed), .tbl_dest(tbl_dest),
        .sched_go(sched_go), .sched_stop(sched_stop),
        .cfg_err(cfg_err), .thr_active(thr_active), .sched_start(sched_start),
        .port_owned(port_owned), .port_closed(port_closed)
    );

    task automatic cyc();
        @(negedge clk);
        tnow = tnow + 1'b1;
    endtask

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s at t=%0d got %0h expected %0h", req, tnow, got, exp);
        end
    endtask

    task automatic wr_tbl(input int a, input int d, input bit en, input int cl, input int ds);
        tbl_waddr = 3'(a); tbl_delta = 8'(d); tbl_gate_en = en;
        tbl_closed = 8'(cl); tbl_dest = 5'(ds); tbl_we = 1;
        cyc(); tbl_we = 0;
    endtask

    task automatic wr_ep(input int t, input int a, input int off, input int e);
        ep_thr = 2'(t); ep_addr_w = 3'(a); ep_off_w = 8'(off); ep_end_w = 3'(e); ep_we = 1;
        cyc(); ep_we = 0;
    endtask

    task automatic wr_base(input int b);
        base_wdata = 16'(b); base_we = 1; cyc(); base_we = 0;
    endtask

    task automatic wr_cnt(input int c);
        cnt_wdata = 2'(c); cnt_we = 1; cyc(); cnt_we = 0;
    endtask

    task automatic go();
        sched_go = 1; cyc(); sched_go = 0;
    endtask

    task automatic halt();
        sched_stop = 1; cyc(); sched_stop = 0;
        check("R10 stop idles all threads", thr_active, 0);
        check("R10 stop clears ports", port_closed, 0);
    endtask

    function automatic int hold(input int j, input int len);
        return 1 + ((j + len) % 3);
    endfunction

    // One thread walking a slice of len entries starting at address a.
    task automatic run_single(input int a, input int len);
        int base, t0, total, tt, s, pos, acc, jj, cl;
        halt();
        for (int j = 0; j < len; j++)
            wr_tbl(a + j, hold(j, len), j != 1, 16 * a + j + 1, 1);
        wr_cnt(0);
        wr_ep(0, a, len, a + len - 1);
        base = int'(tnow) + 10;
        wr_base(base);
        go();
        t0 = base + len * TPD;
        total = 0;
        for (int j = 0; j < len; j++) total += hold(j, len) * TPD;
        while (int'(tnow) < t0 + 3 * total + 2) begin
            cyc();
            tt = int'(tnow) - 1;
            if (tt < t0) begin
                check("R2 idle before start time", thr_active, 0);
                check("R7 unowned before start", port_owned, 0);
                check("R9 no early pulse", sched_start, 0);
            end else begin
                s = tt - t0;
                pos = s % total;
                acc = 0; jj = 0;
                for (int j = 0; j < len; j++) begin
                    if (pos >= acc && pos < acc + hold(j, len) * TPD) jj = j;
                    acc += hold(j, len) * TPD;
                end
                cl = (jj != 1) ? (16 * a + jj + 1) : 0;
                check("R2 thread 0 only active", thr_active, 4'b0001);
                check("R3 R4 walk and hold mask", port_closed[7:0], cl);
                check("R7 port 0 owned", port_owned, 5'b00001);
                check("R9 start pulse", sched_start, s == 0);
            end
        end
    endtask

    initial begin
        #600000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int base, tt;
        bit a0, a1;
        repeat (3) cyc();
        rst_n = 1;
        cyc();
        check("R1 reset active", thr_active, 0);
        check("R1 reset owned", port_owned, 0);
        check("R1 reset closed", port_closed, 0);
        check("R1 reset err", cfg_err, 0);
        check("R1 reset pulse", sched_start, 0);

        // Sweep of slice lengths and positions for a single thread.
        for (int a = 0; a <= 2; a += 2)
            for (int len = 1; len <= 4; len++)
                run_single(a, len);

        // Two threads with overlapping port masks and staggered starts.
        halt();
        wr_tbl(0, 2, 1, 8'hA5, 5'b00110);
        wr_tbl(1, 3, 1, 8'h3C, 5'b00011);
        wr_cnt(1);
        wr_ep(0, 0, 1, 0);
        wr_ep(1, 1, 3, 1);
        base = int'(tnow) + 10;
        wr_base(base);
        go();
        while (int'(tnow) < base + 30) begin
            cyc();
            tt = int'(tnow) - 1;
            a0 = tt >= base + 1 * TPD;
            a1 = tt >= base + 3 * TPD;
            check("R2 count limits threads", thr_active, {2'b00, a1, a0});
            check("R8 port 0 follows thread 1", port_closed[7:0], a1 ? 8'h3C : 8'h00);
            check("R8 port 1 lowest thread wins", port_closed[15:8], a0 ? 8'hA5 : (a1 ? 8'h3C : 8'h00));
            check("R8 port 2 from thread 0", port_closed[23:16], a0 ? 8'hA5 : 8'h00);
            check("R7 owned ports", port_owned, {3'b000, a0 | a1, a1} | {2'b00, a0, 2'b00});
            check("R9 pulse on first activation", sched_start, tt == base + TPD);
        end
        go();
        check("R10 start while running ignored", thr_active, 4'b0011);

        // Stop together with start wins; a later idle period stays idle.
        sched_stop = 1; sched_go = 1; cyc(); sched_stop = 0; sched_go = 0;
        check("R10 stop beats start", thr_active, 0);
        repeat (8) cyc();
        check("R10 remains idle", thr_active, 0);

        // Rejected writes leave stored state untouched.
        wr_tbl(0, 1, 1, 8'h77, 5'b00001);
        check("R5 legal write no error", cfg_err, 0);
        wr_tbl(0, 0, 1, 8'h11, 5'b00001);
        check("R5 zero hold flagged", cfg_err, 1);
        cyc();
        check("R5 flag lasts one cycle", cfg_err, 0);
        wr_cnt(0);
        wr_ep(0, 0, 4, 0);
        check("R6 legal entry point", cfg_err, 0);
        wr_ep(0, 0, 0, 0);
        check("R6 zero offset flagged", cfg_err, 1);
        wr_ep(0, 0, 4, 5);
        check("R6 end above next thread flagged", cfg_err, 1);
        base = int'(tnow) + 10;
        wr_base(base);
        go();
        while (int'(tnow) < base + 20) begin
            cyc();
            tt = int'(tnow) - 1;
            a0 = tt >= base + 4 * TPD;
            check("R6 stored offset kept", thr_active, {3'b000, a0});
            check("R5 stored entry kept", port_closed[7:0], a0 ? 8'h77 : 8'h00);
        end
        halt();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule